// File: doc/BRIEF.md
# Synthesizer Latch Word Loader

This block is a serial master that programs a bank of PLL frequency synthesizers sharing one serial clock line and one serial data line. Each target has its own active-low load-enable line. A host presents a target index, a family selector and three 24-bit latch words in any slot order, then pulses a request. The loader picks the words in the order that the family needs, using each word's two select bits. It shifts each word out MSB first. It then raises the target's load-enable so that the device commits the word to the latch named by those bits.

Two families are supported. The wide-range VCO family takes the reference divider latch first, then the control latch, then the N divider latch. The fixed-frequency PLL family takes the function latch first, then the reference divider latch, then the N divider latch. The host does not need to know either order. The loader drives busy for the whole sequence and pulses done once at its end.

Top module: `pll_latch_loader`

## Requirements
- R1: Out of reset, all load-enable lines are high, and the serial clock, serial data, busy and done are all low.
- R2: Each word is sent most significant bit first, bit 23 down to bit 0. Exactly 24 serial clock rising edges occur while the target's load-enable is low.
- R3: Serial data changes only while the serial clock is low. It is stable for at least DIV/2 system clocks before every serial clock rising edge.
- R4: Load-enable rises on the serial clock falling edge that follows the 24th bit. It then stays high for at least DIV system clocks before the next word's load-enable falls, and the serial clock stays low while all enables are high.
- R5: With req_family = 0 (wide-range VCO family), words are sent in the order of their bits [1:0] = 01, then 00, then 10.
- R6: With req_family = 1 (fixed-frequency family), words are sent in the order of their bits [1:0] = 11, then 00, then 10.
- R7: Slot i of req_slots is bits [24*i+23 : 24*i]. The three words may sit in any slot order, and the order sent depends only on their select bits.
- R8: Only ld_en[req_dev] is ever driven low during a sequence. At most one load-enable is low at any time.
- R9: The serial clock has a period of DIV system clocks with equal high and low halves, and is low whenever busy is low.
- R10: A request made while busy is high is ignored, and no word is sent for it.
- R11: A request with req_dev of 7 or more is ignored, and busy stays low. A request whose family needs a select code that no slot carries is also ignored, and busy stays low.
- R12: Busy rises on the cycle after an accepted request and falls after the last word's load-enable high time. Done is high for exactly one cycle, the first cycle with busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-cycle request to start a sequence |
| req_dev | input | 3 | Target device index, 0 to 6 |
| req_family | input | 1 | 0: wide-range VCO family, 1: fixed-frequency family |
| req_slots | input | 72 | Three 24-bit latch words, slot i at bits 24*i+23:24*i |
| sclk | output | 1 | Shared serial clock, idles low |
| sdata | output | 1 | Shared serial data |
| ld_en | output | 7 | Per-device load-enable lines, idle high |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at sequence end |

## Verification
The bench feeds the same three select codes in natural, shuffled and reversed slot order for both families. A loader that used slot order instead of select bits would commit words in the wrong order, and the scoreboard would report a mismatch. A second request arrives mid-sequence; a loader that accepted it would produce a commit with no matching expectation. Requests with an out-of-range index or a missing select code must leave busy low. A model of the receiving device counts clock edges and measures the high time of load-enable, so an off-by-one in the bit counter, a data change on a rising clock edge, or a shortened load-enable high time each shows up as a failed check.

// File: rtl/pll_ld_pkg.sv
`timescale 1ns/1ps
package pll_ld_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_HOLD  = 2'd2
  } ld_state_e;

  localparam int NSTEP = 3;

  // Select code (word bits [1:0]) required at a given step of a family's order.
  function automatic logic [1:0] step_code(input logic fam, input int step);
    logic [1:0] c;
    if (step == 0)      c = fam ? 2'b11 : 2'b01;
    else if (step == 1) c = 2'b00;
    else                c = 2'b10;
    return c;
  endfunction

endpackage

// File: rtl/pll_ld_order.sv
`timescale 1ns/1ps
module pll_ld_order
  import pll_ld_pkg::*;
#(
  parameter int WORD_W = 24,
  localparam int FLAT_W = NSTEP * WORD_W
) (
  input  logic              fam,
  input  logic [FLAT_W-1:0] slots,
  output logic [FLAT_W-1:0] ordered,
  output logic              all_found
);

  logic [NSTEP-1:0] hit;

  for (genvar s = 0; s < NSTEP; s++) begin : g_step
    logic [WORD_W-1:0] pick;
    logic              found;
    logic [1:0]        want;

    assign want = step_code(fam, s);

    always_comb begin
      pick  = '0;
      found = 1'b0;
      for (int i = NSTEP - 1; i >= 0; i--) begin
        if (slots[i*WORD_W +: 2] == want) begin
          pick  = slots[i*WORD_W +: WORD_W];
          found = 1'b1;
        end
      end
    end

    assign ordered[s*WORD_W +: WORD_W] = pick;
    assign hit[s] = found;
  end

  assign all_found = &hit;

endmodule

// File: rtl/pll_ld_clkdiv.sv
`timescale 1ns/1ps
module pll_ld_clkdiv #(
  parameter int DIV = 4,
  localparam int HALF = DIV / 2,
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  logic [CW-1:0] cnt_q;
  logic          at_end;

  assign at_end = (cnt_q == CW'(HALF - 1));
  assign tick   = run && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run || at_end) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/pll_ld_shifter.sv
`timescale 1ns/1ps
module pll_ld_shifter
  import pll_ld_pkg::*;
#(
  parameter int NDEV    = 7,
  parameter int WORD_W  = 24,
  parameter int LE_HOLD = 1,
  localparam int DEV_W  = (NDEV > 1) ? $clog2(NDEV) : 1,
  localparam int FLAT_W = NSTEP * WORD_W,
  localparam int BIT_W  = $clog2(WORD_W),
  localparam int HOLD_TICKS = 2 * LE_HOLD,
  localparam int HOLD_W = $clog2(HOLD_TICKS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DEV_W-1:0]  dev,
  input  logic [FLAT_W-1:0] words,
  input  logic              tick,
  output logic              run,
  output logic              sclk,
  output logic              sdata,
  output logic [NDEV-1:0]   ld_en,
  output logic              done,
  output logic              commit_evt
);

  ld_state_e         state_q;
  logic              sclk_q, sdata_q, done_q;
  logic [BIT_W-1:0]  bit_q;
  logic [1:0]        step_q;
  logic [HOLD_W-1:0] hold_q;
  logic [FLAT_W-1:0] words_q;
  logic [DEV_W-1:0]  dev_q;
  logic [NDEV-1:0]   le_q;
  logic [WORD_W-1:0] cur_word, next_word;

  function automatic logic [NDEV-1:0] low_mask(input logic [DEV_W-1:0] d);
    logic [NDEV-1:0] m;
    for (int i = 0; i < NDEV; i++) m[i] = (d != DEV_W'(i));
    return m;
  endfunction

  assign cur_word  = words_q[step_q*WORD_W +: WORD_W];
  assign next_word = words_q[(step_q + 2'd1)*WORD_W +: WORD_W];

  assign run   = (state_q != ST_IDLE);
  assign sclk  = sclk_q;
  assign sdata = sdata_q;
  assign ld_en = le_q;
  assign done  = done_q;
  assign commit_evt = (state_q == ST_SHIFT) && tick && sclk_q && (bit_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sclk_q  <= 1'b0;
      sdata_q <= 1'b0;
      done_q  <= 1'b0;
      bit_q   <= '0;
      step_q  <= '0;
      hold_q  <= '0;
      words_q <= '0;
      dev_q   <= '0;
      le_q    <= '1;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            words_q <= words;
            dev_q   <= dev;
            step_q  <= '0;
            bit_q   <= BIT_W'(WORD_W - 1);
            sdata_q <= words[WORD_W-1];
            le_q    <= low_mask(dev);
            state_q <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (!sclk_q) begin
              sclk_q <= 1'b1;
            end else begin
              sclk_q <= 1'b0;
              if (bit_q == '0) begin
                le_q    <= '1;
                sdata_q <= 1'b0;
                hold_q  <= '0;
                state_q <= ST_HOLD;
              end else begin
                bit_q   <= bit_q - 1'b1;
                sdata_q <= cur_word[bit_q - 1'b1];
              end
            end
          end
        end
        ST_HOLD: begin
          if (tick) begin
            if (hold_q == HOLD_W'(HOLD_TICKS - 1)) begin
              if (step_q == 2'(NSTEP - 1)) begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
              end else begin
                step_q  <= step_q + 2'd1;
                bit_q   <= BIT_W'(WORD_W - 1);
                sdata_q <= next_word[WORD_W-1];
                le_q    <= low_mask(dev_q);
                state_q <= ST_SHIFT;
              end
            end else begin
              hold_q <= hold_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pll_latch_loader.sv
`timescale 1ns/1ps
module pll_latch_loader
  import pll_ld_pkg::*;
#(
  parameter int NDEV    = 7,
  parameter int WORD_W  = 24,
  parameter int DIV     = 4,
  parameter int LE_HOLD = 1,
  localparam int DEV_W  = (NDEV > 1) ? $clog2(NDEV) : 1,
  localparam int FLAT_W = NSTEP * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic              req_family,
  input  logic [FLAT_W-1:0] req_slots,
  output logic              sclk,
  output logic              sdata,
  output logic [NDEV-1:0]   ld_en,
  output logic              busy,
  output logic              done
);

  logic [FLAT_W-1:0] ordered;
  logic              codes_ok;
  logic              dev_ok;
  logic              accept;
  logic              run;
  logic              tick;
  logic              commit_evt;

  pll_ld_order #(.WORD_W(WORD_W)) u_order (
    .fam       (req_family),
    .slots     (req_slots),
    .ordered   (ordered),
    .all_found (codes_ok)
  );

  assign dev_ok = (32'(req_dev) < NDEV);
  assign accept = req_valid && !run && codes_ok && dev_ok;

  pll_ld_clkdiv #(.DIV(DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (tick)
  );

  pll_ld_shifter #(
    .NDEV    (NDEV),
    .WORD_W  (WORD_W),
    .LE_HOLD (LE_HOLD)
  ) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .dev        (req_dev),
    .words      (ordered),
    .tick       (tick),
    .run        (run),
    .sclk       (sclk),
    .sdata      (sdata),
    .ld_en      (ld_en),
    .done       (done),
    .commit_evt (commit_evt)
  );

  assign busy = run;

endmodule

// File: rtl/pll_ld_checker.sv
`timescale 1ns/1ps
module pll_ld_checker #(
  parameter int NDEV   = 7,
  parameter int WORD_W = 24,
  localparam int DEV_W = (NDEV > 1) ? $clog2(NDEV) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [DEV_W-1:0] req_dev,
  input logic             sclk,
  input logic             sdata,
  input logic [NDEV-1:0]  ld_en,
  input logic             busy,
  input logic             done,
  input logic             commit_evt
);

  logic       all_hi, all_hi_p, sclk_p;
  logic [7:0] rise_cnt;

  assign all_hi = &ld_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      all_hi_p <= 1'b1;
      sclk_p   <= 1'b0;
      rise_cnt <= '0;
    end else begin
      all_hi_p <= all_hi;
      sclk_p   <= sclk;
      if (all_hi_p && !all_hi)            rise_cnt <= '0;
      else if (sclk && !sclk_p && !all_hi) rise_cnt <= rise_cnt + 8'd1;
    end
  end

  assert_one_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~ld_en) <= 1);

  assert_sclk_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);

  assert_data_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(sdata));

  assert_bit_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |-> (rise_cnt == 8'(WORD_W)));

  assert_clk_low_in_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && all_hi) |-> !sclk);

  assert_bad_dev_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && (32'(req_dev) >= NDEV)) |=> !busy);

  assert_done_shape_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind pll_latch_loader pll_ld_checker #(.NDEV(NDEV), .WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_dev    (req_dev),
  .sclk       (sclk),
  .sdata      (sdata),
  .ld_en      (ld_en),
  .busy       (busy),
  .done       (done),
  .commit_evt (commit_evt)
);

// File: tb/sim_pll_latch_loader.sv
`timescale 1ns/1ps
module sim_pll_latch_loader;

  localparam int NDEV = 7;
  localparam int W    = 24;
  localparam int DIV  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [2:0]    req_dev = '0;
  logic          req_family = 1'b0;
  logic [3*W-1:0] req_slots = '0;
  logic          sclk, sdata, busy, done;
  logic [NDEV-1:0] ld_en;

  int checks = 0;
  int fails  = 0;
  int done_seen = 0;
  int cyc = 0;
  bit finished = 0;

  int          q_dev[$];
  logic [W-1:0] q_word[$];
  string       q_tag[$];

  always #2.5 clk = ~clk;

  pll_latch_loader #(.NDEV(NDEV), .WORD_W(W), .DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dev(req_dev),
    .req_family(req_family), .req_slots(req_slots), .sclk(sclk),
    .sdata(sdata), .ld_en(ld_en), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Required select code per step, restated from R5/R6.
  function automatic logic [1:0] want(input bit fam, input int step);
    logic [1:0] fam0 [3] = '{2'b01, 2'b00, 2'b10};
    logic [1:0] fam1 [3] = '{2'b11, 2'b00, 2'b10};
    return fam ? fam1[step] : fam0[step];
  endfunction

  // Driver: pushes expected commits, then pulses a request.
  task automatic issue(input int dev, input bit fam, input logic [W-1:0] s0,
                       input logic [W-1:0] s1, input logic [W-1:0] s2,
                       input string tag, input bit expect_run);
    logic [W-1:0] sl [3];
    sl = '{s0, s1, s2};
    if (expect_run) begin
      for (int st = 0; st < 3; st++) begin
        for (int k = 0; k < 3; k++) begin
          if (sl[k][1:0] == want(fam, st)) begin
            q_dev.push_back(dev);
            q_word.push_back(sl[k]);
            q_tag.push_back(tag);
            break;
          end
        end
      end
    end
    @(negedge clk);
    req_dev = 3'(dev); req_family = fam; req_slots = {s2, s1, s0};
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: a model of the receiving devices, sampled at negedge.
  logic          p_sclk = 0, p_sdata = 0;
  logic [NDEV-1:0] p_le = '1;
  logic [W-1:0]  shreg = '0;
  int            nbits = 0;
  int            last_edge = 0;
  int            le_rise_cyc = -1000;
  logic          p_busy = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (sclk && !p_sclk) begin
        check(p_sdata == sdata, "R3", "data moved at clock rise", sdata, p_sdata);
        check(!(&ld_en), "R4", "clock rose with all enables high", ld_en, 0);
        check(cyc - last_edge == DIV/2, "R9", "half period before rise", cyc - last_edge, DIV/2);
        last_edge = cyc;
        shreg = {shreg[W-2:0], sdata};
        nbits++;
      end
      if (!sclk && p_sclk) begin
        check(cyc - last_edge == DIV/2, "R9", "half period before fall", cyc - last_edge, DIV/2);
        last_edge = cyc;
      end
      if ((&p_le) && !(&ld_en)) begin
        check($countones(~ld_en) == 1, "R8", "enables low", ld_en, 0);
        if (le_rise_cyc >= 0 && busy && p_busy)
          check(cyc - le_rise_cyc >= DIV, "R4", "enable high time", cyc - le_rise_cyc, DIV);
        nbits = 0;
        last_edge = cyc;
      end
      for (int d = 0; d < NDEV; d++) begin
        if (ld_en[d] && !p_le[d]) begin
          le_rise_cyc = cyc;
          check(nbits == W, "R2", "bits per word", nbits, W);
          if (q_dev.size() == 0) begin
            check(0, "R10", "unexpected commit on dev", d, -1);
          end else begin
            automatic int ed = q_dev.pop_front();
            automatic logic [W-1:0] ew = q_word.pop_front();
            automatic string tg = q_tag.pop_front();
            check(d == ed, tg, "committed device", d, ed);
            check(shreg == ew, tg, "committed word", shreg, ew);
          end
        end
      end
      if (done) begin
        done_seen++;
        check(!busy && p_busy, "R12", "done with busy fall", {busy, p_busy}, 2'b01);
      end
      p_sclk = sclk; p_sdata = sdata; p_le = ld_en; p_busy = busy;
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", "run did not finish", cyc, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ld_en == '1 && !sclk && !sdata && !busy && !done, "R1", "reset outputs",
          {ld_en, sclk, sdata, busy, done}, {7'h7F, 4'h0});
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R5 natural slots, wide-range family, device 0
    issue(0, 0, 24'h5A3C01, 24'h12F000, 24'h00A5FE, "R5", 1);
    check(busy, "R12", "busy after accept", busy, 1);
    wait_done();

    // R6 + R7 shuffled slots, fixed family, device 5
    issue(5, 1, 24'h00C0A2, 24'h8F0013, 24'h345678, "R6", 1);
    wait_done();

    // R7 + R8 reversed slots, wide-range family, highest device
    issue(6, 0, 24'h0ABCD6, 24'hFFFFFC, 24'h800001, "R7", 1);
    wait_done();

    // R10 second request while busy is ignored
    issue(3, 1, 24'h111113, 24'h222220, 24'h33333E, "R10", 1);
    repeat (40) @(negedge clk);
    issue(2, 0, 24'h000001, 24'h000000, 24'h000002, "R10", 0);
    wait_done();
    check(q_dev.size() == 0, "R10", "pending expectations", q_dev.size(), 0);

    // R11 out-of-range device
    issue(7, 0, 24'h000001, 24'h000000, 24'h000002, "R11", 0);
    begin
      bit quiet = 1;
      repeat (30) begin
        if (busy || ld_en != '1 || sclk) quiet = 0;
        @(negedge clk);
      end
      check(quiet, "R11", "idle after bad device", quiet, 1);
    end

    // R11 missing select code for fixed family
    issue(1, 1, 24'h000001, 24'h000000, 24'h000002, "R11", 0);
    begin
      bit quiet = 1;
      repeat (30) begin
        if (busy || ld_en != '1 || sclk) quiet = 0;
        @(negedge clk);
      end
      check(quiet, "R11", "idle after missing code", quiet, 1);
    end

    check(done_seen == 4, "R12", "done pulse count", done_seen, 4);
    check(q_dev.size() == 0, "R10", "scoreboard drained", q_dev.size(), 0);
    summary();
  end

endmodule